// File: doc/BRIEF.md
# Frame-Locked Line Clock DPLL

This block makes a line clock at one eighth of the crystal rate (1.544 MHz from a 12.352 MHz crystal) and pulls its phase toward an active-low 8 kHz frame pulse. A divider normally counts eight crystal cycles per output period. Each frame pulse is passed through a two-flop synchronizer, and its falling edge samples the divider's phase. Small phase errors inside a dead-band are left alone, so slow wander in the reference never reaches the output. A larger error stretches one output period to nine crystal cycles or shortens one to seven.

A three-state controller tracks how well the loop is following its reference. In FREE the divider runs at a fixed divide-by-8. A reference edge moves it to ACQUIRE. Sixteen reference edges in a row that need no correction move it to LOCKED. A correction of more than one cycle beyond the window drops LOCKED back to ACQUIRE. A missing reference, or the free-run mode pin, returns the controller to FREE. The block must be reset after power-up.

Top module: `line_clk_dpll`

## Requirements
- R1: After reset the line clock repeats every 8 crystal cycles: high for 4 and low for 4. A period begins on the crystal edge that raises `line_clk`. With no reference the period stays at 8.
- R2: The phase offset d of a reference is counted in crystal edges. d = 0 when `frame_n` is sampled low on the edge just before the edge that raises `line_clk`. The error is d wrapped into the range -4..+3, so d = 4..7 reads as d-8.
- R3: A reference whose error magnitude is at most DEAD_WIN (default 1) leaves every period at 8.
- R4: An error above +DEAD_WIN makes exactly one period 9 cycles, and an error below -DEAD_WIN makes exactly one period 7 cycles. The adjusted period is the first one that begins on or after the second crystal edge after `frame_n` was sampled low. The periods on either side stay at 8.
- R5: `locked` rises on the 16th consecutive reference that needs no correction, and not before.
- R6: While locked, a correction with error magnitude DEAD_WIN+1 keeps `locked` high. A larger error magnitude clears it.
- R7: If no reference edge arrives for 1.5 frame times (2316 crystal cycles), the controller enters FREE, `locked` clears, and the period returns to a fixed 8.
- R8: `mode_sel[1]` = 1 selects free-run, in which references cause no correction. `mode_sel[1]` = 0 selects normal tracking, and `mode_sel[0]` is ignored.
- R9: While `rst_n` is low, `line_clk` and `locked` are 0 and the controller is in FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal clock, eight times the line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame reference pulse, one crystal cycle wide |
| mode_sel | input | 2 | Mode pins; bit 1 = 1 selects free-run, bit 0 is ignored |
| line_clk | output | 1 | Generated line clock |
| locked | output | 1 | High while the loop is in LOCKED |

## Verification
The bench places each reference at every offset d from 0 to 7 relative to a line clock rise. It then measures the next three periods, which exposes an off-by-one in the dead-band: a design that gets this wrong would correct at ±1 or ignore ±2. The same measurement catches a period adjusted one frame late, or adjusted twice. The offset d = 7, whose decision lands on the wrap edge, targets a divider that loses a correction arriving on the same cycle as its wrap. The lock tests probe the 15th and 16th good references, a ±2 correction while locked, a ±3 correction while locked, and the point just before and just after the timeout; together these expose a miscounted lock threshold and a lock flag that is never cleared. Free-run mode is checked with bit 1 set, and `mode_sel[0]` is checked to have no effect.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2
    } loop_state_t;

    typedef enum logic [1:0] {
        CORR_NONE    = 2'd0,
        CORR_STRETCH = 2'd1,
        CORR_SHORTEN = 2'd2
    } corr_t;

endpackage

// File: rtl/frame_sync.sv
module frame_sync #(
    parameter int STAGES = 2
) (
    input  logic xtal_clk,
    input  logic rst_n,
    input  logic frame_n,
    output logic ref_edge
);
    // Synchronizer stages followed by one extra flop for the edge detector.
    logic [STAGES:0] shift_q;

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '1;
        end else begin
            shift_q <= {shift_q[STAGES-1:0], frame_n};
        end
    end

    assign ref_edge = shift_q[STAGES] & ~shift_q[STAGES-1];

endmodule

// File: rtl/phase_det.sv
module phase_det
    import dpll_pkg::*;
#(
    parameter int NOM = 8,
    parameter int WIN = 1,
    parameter int CW  = 4
) (
    input  logic          ref_edge,
    input  logic          enable,
    input  logic [CW-1:0] phase,
    output corr_t         corr_req,
    output logic          big_err
);
    localparam int HALF = NOM / 2;

    int err;
    int mag;

    always_comb begin
        // Wrap the sampled count into a signed error around zero.
        err = int'(phase);
        if (err >= HALF) begin
            err = err - NOM;
        end
        mag = (err < 0) ? -err : err;

        corr_req = CORR_NONE;
        big_err  = 1'b0;
        if (ref_edge && enable) begin
            if (err > WIN) begin
                corr_req = CORR_STRETCH;
            end else if (err < -WIN) begin
                corr_req = CORR_SHORTEN;
            end
            big_err = (mag > WIN + 1);
        end
    end

endmodule

// File: rtl/period_div.sv
module period_div
    import dpll_pkg::*;
#(
    parameter int NOM = 8,
    parameter int CW  = 4
) (
    input  logic          xtal_clk,
    input  logic          rst_n,
    input  corr_t         corr_req,
    output logic [CW-1:0] phase,
    output logic          line_clk
);
    localparam int HALF = NOM / 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] last_q;
    corr_t         pend_q;
    corr_t         pend_nxt;
    logic          wrap;
    logic          clk_q;

    function automatic logic [CW-1:0] last_of(corr_t c);
        unique case (c)
            CORR_STRETCH: return CW'(NOM);
            CORR_SHORTEN: return CW'(NOM - 2);
            default:      return CW'(NOM - 1);
        endcase
    endfunction

    always_comb begin
        wrap     = (cnt_q == last_q);
        pend_nxt = (corr_req != CORR_NONE) ? corr_req : pend_q;
        cnt_nxt  = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= CW'(NOM - 1);
            last_q <= CW'(NOM - 1);
            pend_q <= CORR_NONE;
            clk_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            clk_q <= (cnt_nxt < CW'(HALF));
            if (wrap) begin
                // A decision on the wrap edge shapes the period that starts now.
                last_q <= last_of(pend_nxt);
                pend_q <= CORR_NONE;
            end else begin
                pend_q <= pend_nxt;
            end
        end
    end

    assign phase    = cnt_q;
    assign line_clk = clk_q;

    a_r1_count_bound: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        cnt_q <= CW'(NOM));

    a_r4_period_span: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        $rose(clk_q) |-> ($past(cnt_q) >= CW'(NOM - 2)));

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import dpll_pkg::*;
#(
    parameter int LOCK_REFS = 16,
    parameter int TIMEOUT   = 2316
) (
    input  logic  xtal_clk,
    input  logic  rst_n,
    input  logic  normal_mode,
    input  logic  ref_edge,
    input  corr_t corr_req,
    input  logic  big_err,
    output logic  locked
);
    localparam int GW = $clog2(LOCK_REFS + 1);
    localparam int TW = $clog2(TIMEOUT + 1);

    loop_state_t   state_q;
    loop_state_t   state_nxt;
    logic [GW-1:0] good_q;
    logic [TW-1:0] tmo_q;
    logic          seen;
    logic          clean;
    logic          expired;

    always_comb begin
        seen    = ref_edge && normal_mode;
        clean   = seen && (corr_req == CORR_NONE);
        expired = (state_q != ST_FREE) && !seen && (tmo_q == TW'(TIMEOUT - 1));
    end

    // Next state.
    always_comb begin
        state_nxt = state_q;
        if (!normal_mode) begin
            state_nxt = ST_FREE;
        end else begin
            unique case (state_q)
                ST_FREE: begin
                    if (seen) state_nxt = ST_ACQ;
                end
                ST_ACQ: begin
                    if (expired) begin
                        state_nxt = ST_FREE;
                    end else if (clean && good_q == GW'(LOCK_REFS - 1)) begin
                        state_nxt = ST_LOCK;
                    end
                end
                ST_LOCK: begin
                    if (expired) begin
                        state_nxt = ST_FREE;
                    end else if (seen && big_err) begin
                        state_nxt = ST_ACQ;
                    end
                end
                default: state_nxt = ST_FREE;
            endcase
        end
    end

    // State register with its run counters.
    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            good_q  <= '0;
            tmo_q   <= '0;
        end else begin
            state_q <= state_nxt;
            if (!normal_mode || expired) begin
                good_q <= '0;
            end else if (seen) begin
                if (!clean) begin
                    good_q <= '0;
                end else if (good_q != GW'(LOCK_REFS - 1)) begin
                    good_q <= good_q + 1'b1;
                end
            end
            if (seen || state_q == ST_FREE) begin
                tmo_q <= '0;
            end else if (tmo_q != TW'(TIMEOUT - 1)) begin
                tmo_q <= tmo_q + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        locked = (state_q == ST_LOCK);
    end

    a_r5_lock_on_ref: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_edge));

    a_r7_timeout_drop: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        expired |=> !locked);

    a_r8_mode_free: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        !normal_mode |=> state_q == ST_FREE);

endmodule

// File: rtl/line_clk_dpll.sv
module line_clk_dpll
    import dpll_pkg::*;
#(
    parameter int NOM_DIV     = 8,
    parameter int DEAD_WIN    = 1,
    parameter int LOCK_REFS   = 16,
    parameter int FRAME_CYC   = 1544,
    parameter int SYNC_STAGES = 2
) (
    input  logic       xtal_clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic [1:0] mode_sel,
    output logic       line_clk,
    output logic       locked
);
    localparam int CW      = $clog2(NOM_DIV + 1);
    localparam int TIMEOUT = FRAME_CYC + FRAME_CYC / 2;

    logic          ref_edge;
    logic          normal_mode;
    logic [CW-1:0] phase;
    corr_t         corr_req;
    logic          big_err;

    assign normal_mode = ~mode_sel[1];

    frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .xtal_clk (xtal_clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .ref_edge (ref_edge)
    );

    phase_det #(.NOM(NOM_DIV), .WIN(DEAD_WIN), .CW(CW)) u_pd (
        .ref_edge (ref_edge),
        .enable   (normal_mode),
        .phase    (phase),
        .corr_req (corr_req),
        .big_err  (big_err)
    );

    period_div #(.NOM(NOM_DIV), .CW(CW)) u_div (
        .xtal_clk (xtal_clk),
        .rst_n    (rst_n),
        .corr_req (corr_req),
        .phase    (phase),
        .line_clk (line_clk)
    );

    lock_fsm #(.LOCK_REFS(LOCK_REFS), .TIMEOUT(TIMEOUT)) u_fsm (
        .xtal_clk    (xtal_clk),
        .rst_n       (rst_n),
        .normal_mode (normal_mode),
        .ref_edge    (ref_edge),
        .corr_req    (corr_req),
        .big_err     (big_err),
        .locked      (locked)
    );

    a_r8_no_corr_freerun: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        mode_sel[1] |-> corr_req == CORR_NONE);

    a_r3_window_quiet: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        (corr_req != CORR_NONE) |-> ref_edge);

endmodule

// File: tb/line_clk_dpll_test.sv
module line_clk_dpll_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int VD [0:NV-1] = '{0, 1, 7, 2, 3, 4, 5, 6};
    localparam int VP [0:NV-1] = '{8, 8, 8, 9, 9, 7, 7, 7};

    logic       xtal_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic       frame_n  = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       line_clk;
    logic       locked;

    int cyc = 0;
    int nr  = 0;
    int rises [0:15];
    logic lc_prev = 1'b0;
    int checks = 0;
    int errors = 0;
    int last_dec = 0;
    bit done = 1'b0;

    line_clk_dpll uut (
        .xtal_clk (xtal_clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .mode_sel (mode_sel),
        .line_clk (line_clk),
        .locked   (locked)
    );

    always #(CLK_PERIOD / 2) xtal_clk = ~xtal_clk;

    always @(posedge xtal_clk) cyc <= cyc + 1;

    // Rise recorder, sampled between the edges.
    always @(posedge xtal_clk) begin
        #3;
        if (line_clk && !lc_prev) begin
            rises[nr % 16] = cyc;
            nr = nr + 1;
        end
        lc_prev = line_clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise(output int idx);
        int n0;
        n0 = nr;
        while (nr == n0) @(negedge xtal_clk);
        idx = nr - 1;
    endtask

    task automatic pulse_at(input int k);
        @(negedge xtal_clk);
        while (cyc < k - 1) @(negedge xtal_clk);
        frame_n = 1'b0;
        @(negedge xtal_clk);
        frame_n = 1'b1;
    endtask

    // Place a reference at offset d from the next rise; check three periods.
    task automatic run_vec(input int d, input int exp, input string tag);
        int i0;
        int e0;
        int p0;
        int p1;
        int p2;
        wait_rise(i0);
        e0 = rises[i0 % 16];
        pulse_at(e0 + 7 + d);
        last_dec = e0 + 9 + d;
        while (nr < i0 + 5) @(negedge xtal_clk);
        p0 = rises[(i0 + 2) % 16] - rises[(i0 + 1) % 16];
        p1 = rises[(i0 + 3) % 16] - rises[(i0 + 2) % 16];
        p2 = rises[(i0 + 4) % 16] - rises[(i0 + 3) % 16];
        chk(p0 == 8, {tag, " period before"}, p0, 8);
        chk(p1 == exp, {tag, " adjusted period"}, p1, exp);
        chk(p2 == 8, {tag, " period after"}, p2, 8);
    endtask

    initial begin
        repeat (150000) @(posedge xtal_clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ia;
        int ib;
        int per;

        // R9: reset state.
        repeat (3) @(negedge xtal_clk);
        chk(line_clk == 1'b0, "R9 line_clk in reset", int'(line_clk), 0);
        chk(locked == 1'b0, "R9 locked in reset", int'(locked), 0);
        rst_n = 1'b1;

        // R1: free periods with no reference.
        wait_rise(ia);
        wait_rise(ib);
        per = rises[ib % 16] - rises[ia % 16];
        chk(per == 8, "R1 nominal period", per, 8);
        @(posedge xtal_clk); #3;
        chk(line_clk == 1'b1, "R1 high phase", int'(line_clk), 1);
        repeat (4) @(posedge xtal_clk); #3;
        chk(line_clk == 1'b0, "R1 low phase", int'(line_clk), 0);

        // R2 R3 R4: offset table.
        for (int v = 0; v < NV; v++) begin
            run_vec(VD[v], VP[v], $sformatf("R2/R3/R4 d=%0d", VD[v]));
        end

        // R5: lock after sixteen clean references.
        for (int i = 1; i <= 16; i++) begin
            run_vec(0, 8, "R5 clean ref");
            if (i == 15) chk(locked == 1'b0, "R5 not locked at 15", int'(locked), 0);
        end
        chk(locked == 1'b1, "R5 locked at 16", int'(locked), 1);

        // R6: small correction keeps lock, large one drops it.
        run_vec(2, 9, "R6 error +2");
        chk(locked == 1'b1, "R6 lock kept at +2", int'(locked), 1);
        run_vec(3, 9, "R6 error +3");
        chk(locked == 1'b0, "R6 lock dropped at +3", int'(locked), 0);

        // R7: relock, then starve the reference.
        for (int i = 0; i < 16; i++) run_vec(0, 8, "R7 relock");
        chk(locked == 1'b1, "R7 locked before starve", int'(locked), 1);
        while (cyc < last_dec + 2200) @(negedge xtal_clk);
        chk(locked == 1'b1, "R7 still locked before timeout", int'(locked), 1);
        while (cyc < last_dec + 2400) @(negedge xtal_clk);
        chk(locked == 1'b0, "R7 unlocked after timeout", int'(locked), 0);
        wait_rise(ia);
        wait_rise(ib);
        per = rises[ib % 16] - rises[ia % 16];
        chk(per == 8, "R7 free period", per, 8);

        // R8: mode pins.
        mode_sel = 2'b10;
        run_vec(2, 8, "R8 freerun ignores +2");
        run_vec(5, 8, "R8 freerun ignores -3");
        chk(locked == 1'b0, "R8 no lock in freerun", int'(locked), 0);
        mode_sel = 2'b01;
        run_vec(5, 7, "R8 bit0 ignored -3");
        run_vec(2, 9, "R8 bit0 ignored +2");
        mode_sel = 2'b00;
        run_vec(1, 8, "R8 normal window");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule